// File: doc/BRIEF.md
# Programmable Min/Max Gate Row Fitness Evaluator

This block scores one candidate circuit for a median search. The candidate is a single row of programmable two-input elements. Each element takes two source indices and a one-bit function code. Each source names either a primary input or an earlier element. A final index picks which node drives the circuit output.

On a start pulse the block captures the genotype and checks that it is legal. It then steps through every binary input pattern of the NIN primary inputs. Each step covers thirty-two patterns, carried in 32-bit lanes so that each lane holds one pattern. For every pattern it compares the selected node against the majority value, which is the median of binary inputs. At the end it reports three results: the number of matching patterns, whether the genotype was legal, and how many elements the output actually depends on.

The genotype generator and its mutation logic sit outside this block. They drive the flat source vectors, hold them steady for the start cycle, and wait for the done pulse.

Top module: `minmax_row_eval`

## Requirements
- R1: A start pulse while idle captures the genotype and raises busy on the next cycle. A start pulse while busy is ignored, and the result belongs to the genotype captured first.
- R2: Node index i < NIN is primary input i. Node index NIN+j is element j. Element j's source fields occupy bits [j*IW +: IW] of src_a and src_b. out_sel may name any node.
- R3: Function bit j of fn_bits set to 0 makes element j the bitwise AND (minimum) of its sources. Set to 1, it makes element j the bitwise OR (maximum).
- R4: The genotype is legal only when all three conditions hold:
  - every source of element j is below NIN+j;
  - every source that names an element lies at most LBACK elements back (j minus source element ≤ LBACK);
  - out_sel is below NIN+NELEM.

  If any condition fails, chrom_valid is 0 and fitness is 0.
- R5: For a legal genotype, fitness equals the number of the 2^NIN input patterns for which the selected node equals the majority of the inputs. Primary input i takes bit i of the pattern number.
- R6: used_cnt equals the number of elements reachable backward from out_sel through source links. It is 0 when out_sel names a primary input.
- R7: done pulses for exactly one cycle. It appears ceil(2^NIN/32) cycles after the edge that captured start. busy falls at the same edge, and the results hold until the next start.
- R8: After reset, busy, done, chrom_valid, fitness and used_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture genotype and begin scoring |
| src_a | input | NELEM*IW | First source index of each element |
| src_b | input | NELEM*IW | Second source index of each element |
| fn_bits | input | NELEM | Function bit per element (0 AND, 1 OR) |
| out_sel | input | IW | Node index driving the output |
| busy | output | 1 | Scoring in progress |
| done | output | 1 | One-cycle result strobe |
| chrom_valid | output | 1 | Genotype legality of the last run |
| fitness | output | NIN+1 | Count of patterns giving the median |
| used_cnt | output | $clog2(NELEM+1) | Elements reachable from the output |

## Verification
The bench targets the following corner cases:
- A source exactly LBACK elements back against one a step further; a design with an off-by-one window accepts or rejects the wrong one.
- A self-reference and an out-of-range output index; a lax check reports nonzero fitness.
- An output taken straight from a primary input; a reachability pass that counts the output node itself reports one element instead of zero.
- A multi-step run (NIN=7, four steps) against a single-step run; stale accumulation or wrong lane masking miscounts patterns.
- A restart pulse during a run; a design that recaptures it scores the second genotype.

A three-input genotype that computes the median leaves two elements dead. It must score the full eight with four used elements.

// File: rtl/minmax_row_pkg.sv
package minmax_row_pkg;

   typedef enum logic {
      FN_MIN = 1'b0,
      FN_MAX = 1'b1
   } elem_fn_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;

   function automatic logic [6:0] lane_pop(input logic [31:0] w);
      logic [6:0] c;
      c = '0;
      for (int k = 0; k < 32; k++) c = c + 7'(w[k]);
      return c;
   endfunction

endpackage

// File: rtl/minmax_row_patgen.sv
module minmax_row_patgen #(
   parameter int NIN  = 3,
   parameter int WORD = 32,
   parameter int BW   = 1
) (
   input  logic [BW-1:0]               step,
   output logic [NIN-1:0][WORD-1:0]    in_words,
   output logic [WORD-1:0]             med_word,
   output logic [WORD-1:0]             lane_mask
);
   localparam logic [31:0] NPAT = 32'd1 << NIN;

   always_comb begin
      logic [31:0] pat;
      int          ones;
      in_words  = '0;
      med_word  = '0;
      lane_mask = '0;
      for (int k = 0; k < WORD; k++) begin
         pat          = 32'(step) * 32'(WORD) + 32'(k);
         lane_mask[k] = (pat < NPAT);
         ones         = 0;
         for (int i = 0; i < NIN; i++) begin
            in_words[i][k] = pat[i];
            ones           = ones + int'(pat[i]);
         end
         med_word[k] = (ones > NIN / 2);
      end
   end

   always_comb begin
      a_r5_first_lane_live: assert (lane_mask[0] || step != '0);
   end
endmodule

// File: rtl/minmax_row_array.sv
module minmax_row_array
   import minmax_row_pkg::*;
#(
   parameter int NIN   = 3,
   parameter int NELEM = 8,
   parameter int IW    = 4,
   parameter int WORD  = 32
) (
   input  logic [NIN-1:0][WORD-1:0] in_words,
   input  logic [NELEM*IW-1:0]      src_a,
   input  logic [NELEM*IW-1:0]      src_b,
   input  logic [NELEM-1:0]         fn_bits,
   input  logic [IW-1:0]            out_sel,
   output logic [WORD-1:0]          out_word
);
   localparam int NNODE = NIN + NELEM;

   logic [NNODE-1:0][WORD-1:0] node;

   always_comb begin
      logic [WORD-1:0] opa, opb;
      node = '0;
      for (int i = 0; i < NIN; i++) node[i] = in_words[i];
      for (int j = 0; j < NELEM; j++) begin
         opa = '0;
         opb = '0;
         for (int i = 0; i < NIN + j; i++) begin
            if (src_a[j*IW +: IW] == IW'(i)) opa = node[i];
            if (src_b[j*IW +: IW] == IW'(i)) opb = node[i];
         end
         if (elem_fn_e'(fn_bits[j]) == FN_MAX) node[NIN+j] = opa | opb;
         else                                   node[NIN+j] = opa & opb;
      end
      out_word = '0;
      for (int i = 0; i < NNODE; i++)
         if (out_sel == IW'(i)) out_word = node[i];
   end
endmodule

// File: rtl/minmax_row_reach.sv
module minmax_row_reach #(
   parameter int NIN   = 3,
   parameter int NELEM = 8,
   parameter int LBACK = 8,
   parameter int IW    = 4,
   parameter int UW    = 4
) (
   input  logic [NELEM*IW-1:0] src_a,
   input  logic [NELEM*IW-1:0] src_b,
   input  logic [IW-1:0]       out_sel,
   output logic [UW-1:0]       used_cnt,
   output logic                chrom_ok
);
   logic [NELEM-1:0] need;

   function automatic logic src_legal(input int s, input int j);
      if (s >= NIN + j) return 1'b0;
      if (s >= NIN && (j - (s - NIN)) > LBACK) return 1'b0;
      return 1'b1;
   endfunction

   always_comb begin
      need = '0;
      for (int j = NELEM - 1; j >= 0; j--) begin
         need[j] = (out_sel == IW'(NIN + j));
         for (int k = j + 1; k < NELEM; k++)
            if (need[k] && (src_a[k*IW +: IW] == IW'(NIN + j) ||
                            src_b[k*IW +: IW] == IW'(NIN + j)))
               need[j] = 1'b1;
      end
      used_cnt = '0;
      for (int j = 0; j < NELEM; j++) used_cnt = used_cnt + UW'(need[j]);
   end

   always_comb begin
      chrom_ok = (int'(out_sel) < NIN + NELEM);
      for (int j = 0; j < NELEM; j++) begin
         if (!src_legal(int'(src_a[j*IW +: IW]), j)) chrom_ok = 1'b0;
         if (!src_legal(int'(src_b[j*IW +: IW]), j)) chrom_ok = 1'b0;
      end
   end

   always_comb begin
      a_r6_no_used_when_input: assert (int'(out_sel) >= NIN || used_cnt == '0);
   end
endmodule

// File: rtl/minmax_row_eval.sv
module minmax_row_eval
   import minmax_row_pkg::*;
#(
   parameter int NIN   = 3,
   parameter int NELEM = 8,
   parameter int LBACK = 8,
   parameter int WORD  = 32,
   localparam int IW   = $clog2(NIN + NELEM),
   localparam int UW   = $clog2(NELEM + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [NELEM*IW-1:0]   src_a,
   input  logic [NELEM*IW-1:0]   src_b,
   input  logic [NELEM-1:0]      fn_bits,
   input  logic [IW-1:0]         out_sel,
   output logic                  busy,
   output logic                  done,
   output logic                  chrom_valid,
   output logic [NIN:0]          fitness,
   output logic [UW-1:0]         used_cnt
);
   localparam int NPAT = 1 << NIN;
   localparam int NSTEP = (NPAT + WORD - 1) / WORD;
   localparam int BW = (NSTEP > 1) ? $clog2(NSTEP) : 1;
   localparam int FW = NIN + 1;

   generate
      if (NIN < 3 || (NIN % 2) == 0) begin : g_bad_nin
         $error("NIN must be odd and at least 3");
      end
      if (NIN > 20) begin : g_big_nin
         $error("NIN above 20 exceeds the pattern counter");
      end
      if (WORD != 32) begin : g_bad_word
         $error("WORD must be 32 to match the lane counter");
      end
      if (LBACK < 1 || LBACK > NELEM) begin : g_bad_lback
         $error("LBACK must lie in 1..NELEM");
      end
   endgenerate

   run_state_e              state;
   logic [BW-1:0]           step;
   logic [FW-1:0]           acc;
   logic [NELEM*IW-1:0]     cap_a, cap_b;
   logic [NELEM-1:0]        cap_fn;
   logic [IW-1:0]           cap_out;

   logic [NIN-1:0][WORD-1:0] in_words;
   logic [WORD-1:0]          med_word, lane_mask, out_word, hit_word;
   logic [UW-1:0]            used_now;
   logic                     legal_now;
   logic [FW-1:0]            acc_next;

   minmax_row_patgen #(.NIN(NIN), .WORD(WORD), .BW(BW)) patgen_i (
      .step(step), .in_words(in_words), .med_word(med_word), .lane_mask(lane_mask)
   );

   minmax_row_array #(.NIN(NIN), .NELEM(NELEM), .IW(IW), .WORD(WORD)) array_i (
      .in_words(in_words), .src_a(cap_a), .src_b(cap_b), .fn_bits(cap_fn),
      .out_sel(cap_out), .out_word(out_word)
   );

   minmax_row_reach #(.NIN(NIN), .NELEM(NELEM), .LBACK(LBACK), .IW(IW), .UW(UW)) reach_i (
      .src_a(cap_a), .src_b(cap_b), .out_sel(cap_out),
      .used_cnt(used_now), .chrom_ok(legal_now)
   );

   assign hit_word = ~(out_word ^ med_word) & lane_mask;
   assign acc_next = acc + FW'(lane_pop(hit_word));
   assign busy     = (state == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         step        <= '0;
         acc         <= '0;
         cap_a       <= '0;
         cap_b       <= '0;
         cap_fn      <= '0;
         cap_out     <= '0;
         done        <= 1'b0;
         chrom_valid <= 1'b0;
         fitness     <= '0;
         used_cnt    <= '0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               cap_a   <= src_a;
               cap_b   <= src_b;
               cap_fn  <= fn_bits;
               cap_out <= out_sel;
               step    <= '0;
               acc     <= '0;
               state   <= ST_RUN;
            end
         end else begin
            acc  <= acc_next;
            step <= step + 1'b1;
            if (step == BW'(NSTEP - 1)) begin
               state       <= ST_IDLE;
               done        <= 1'b1;
               chrom_valid <= legal_now;
               fitness     <= legal_now ? acc_next : '0;
               used_cnt    <= used_now;
            end
         end
      end
   end

   a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r4_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !chrom_valid) |-> fitness == '0);
   a_r5_fit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int'(fitness) <= NPAT);
   a_r6_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int'(used_cnt) <= NELEM);
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(fitness) && $stable(used_cnt));
endmodule

// File: tb/minmax_row_eval_tb.sv
module minmax_row_eval_tb_top;
   localparam int CLK_P = 10;
   localparam int N1 = 7, P1 = 12, L1 = 8;
   localparam int IW1 = $clog2(N1 + P1);
   localparam int UW1 = $clog2(P1 + 1);
   localparam int STEPS1 = ((1 << N1) + 31) / 32;
   localparam int N2 = 3, P2 = 6, L2 = 6;
   localparam int IW2 = $clog2(N2 + P2);
   localparam int UW2 = $clog2(P2 + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P / 2) clk = ~clk;

   logic               start1 = 1'b0;
   logic [P1*IW1-1:0]  a1 = '0, b1 = '0;
   logic [P1-1:0]      f1 = '0;
   logic [IW1-1:0]     o1 = '0;
   logic               busy1, done1, val1;
   logic [N1:0]        fit1;
   logic [UW1-1:0]     used1;

   logic               start2 = 1'b0;
   logic [P2*IW2-1:0]  a2 = '0, b2 = '0;
   logic [P2-1:0]      f2 = '0;
   logic [IW2-1:0]     o2 = '0;
   logic               busy2, done2, val2;
   logic [N2:0]        fit2;
   logic [UW2-1:0]     used2;

   minmax_row_eval #(.NIN(N1), .NELEM(P1), .LBACK(L1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start1), .src_a(a1), .src_b(b1),
      .fn_bits(f1), .out_sel(o1), .busy(busy1), .done(done1),
      .chrom_valid(val1), .fitness(fit1), .used_cnt(used1)
   );

   minmax_row_eval #(.NIN(N2), .NELEM(P2), .LBACK(L2)) dut3_i (
      .clk(clk), .rst_n(rst_n), .start(start2), .src_a(a2), .src_b(b2),
      .fn_bits(f2), .out_sel(o2), .busy(busy2), .done(done2),
      .chrom_valid(val2), .fitness(fit2), .used_cnt(used2)
   );

   int checks = 0;
   int fails = 0;
   int ga[P1], gb[P1], gf[P1];
   int go;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int m_valid();
      if (go >= N1 + P1) return 0;
      for (int j = 0; j < P1; j++) begin
         if (ga[j] >= N1 + j || gb[j] >= N1 + j) return 0;
         if (ga[j] >= N1 && j - (ga[j] - N1) > L1) return 0;
         if (gb[j] >= N1 && j - (gb[j] - N1) > L1) return 0;
      end
      return 1;
   endfunction

   function automatic int m_fit();
      int nd[N1 + P1];
      int cnt = 0;
      if (m_valid() == 0) return 0;
      for (int v = 0; v < (1 << N1); v++) begin
         int ones = 0;
         for (int i = 0; i < N1; i++) begin
            nd[i] = (v >> i) & 1;
            ones += nd[i];
         end
         for (int j = 0; j < P1; j++)
            nd[N1 + j] = gf[j] ? (nd[ga[j]] | nd[gb[j]]) : (nd[ga[j]] & nd[gb[j]]);
         if (nd[go] == ((ones > N1 / 2) ? 1 : 0)) cnt++;
      end
      return cnt;
   endfunction

   function automatic int m_used();
      int need[P1];
      int c = 0;
      for (int j = P1 - 1; j >= 0; j--) begin
         need[j] = (go == N1 + j) ? 1 : 0;
         for (int k = j + 1; k < P1; k++)
            if (need[k] != 0 && (ga[k] == N1 + j || gb[k] == N1 + j)) need[j] = 1;
         c += need[j];
      end
      return c;
   endfunction

   task automatic drive1();
      for (int j = 0; j < P1; j++) begin
         a1[j*IW1 +: IW1] = IW1'(ga[j]);
         b1[j*IW1 +: IW1] = IW1'(gb[j]);
         f1[j] = gf[j][0];
      end
      o1 = IW1'(go);
   endtask

   task automatic run1(input string tag);
      int ev, ef, eu, cyc;
      ev = m_valid(); ef = m_fit(); eu = m_used();
      drive1();
      @(negedge clk) start1 = 1'b1;
      @(negedge clk) start1 = 1'b0;
      cyc = 1;
      while (!done1) begin
         @(negedge clk);
         cyc++;
      end
      chk({tag, " R4 valid"}, int'(val1), ev);
      chk({tag, " R5 fitness"}, int'(fit1), ef);
      chk({tag, " R6 used"}, int'(used1), eu);
      chk({tag, " R7 latency"}, cyc, STEPS1 + 1);
   endtask

   task automatic chain_base();
      for (int j = 0; j < P1; j++) begin
         ga[j] = j % N1;
         gb[j] = (j + 1) % N1;
         gf[j] = j & 1;
      end
   endtask

   function automatic int rnd_src(input int j);
      int w, r;
      if ($urandom % 16 == 0) return int'($urandom % 32);
      w = (j < L1) ? j : L1;
      r = int'($urandom % (N1 + w));
      if (r < N1) return r;
      return N1 + j - 1 - (r - N1);
   endfunction

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int sf, su, sv;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 busy", int'(busy1), 0);
      chk("R8 done", int'(done1), 0);
      chk("R8 valid", int'(val1), 0);
      chk("R8 fitness", int'(fit1), 0);
      chk("R8 used", int'(used1), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R2: three-input median genotype, elements 4 and 8 dead
      a2 = {4'd0, 4'd3, 4'd0, 4'd1, 4'd2, 4'd1};
      b2 = {4'd7, 4'd6, 4'd5, 4'd2, 4'd2, 4'd2};
      f2 = 6'b101001;
      o2 = 4'd7;
      @(negedge clk) start2 = 1'b1;
      @(negedge clk) start2 = 1'b0;
      while (!done2) @(negedge clk);
      chk("R3 median valid", int'(val2), 1);
      chk("R3 median fitness", int'(fit2), 8);
      chk("R6 median used", int'(used2), 4);
      // R2 output on last element: in0 OR median, one pattern wrong
      o2 = 4'd8;
      @(negedge clk) start2 = 1'b1;
      @(negedge clk) start2 = 1'b0;
      while (!done2) @(negedge clk);
      chk("R2 alt out fitness", int'(fit2), 7);
      chk("R6 alt out used", int'(used2), 5);

      // R6 output on primary input
      chain_base(); go = 0;
      run1("R6 input out");
      // R2 last element output
      chain_base(); go = N1 + P1 - 1;
      run1("R2 chain");
      // R4 self reference
      chain_base(); ga[0] = N1; go = N1 + 3;
      run1("R4 self ref");
      // R4 window edge: exactly LBACK back is legal
      chain_base(); ga[9] = N1 + 1; go = N1 + 9;
      run1("R4 edge ok");
      chain_base(); gb[10] = N1 + 1; go = N1 + 10;
      run1("R4 beyond window");
      // R4 output out of range
      chain_base(); go = N1 + P1;
      run1("R4 out range");

      // R1 start while busy is ignored
      chain_base(); go = N1 + 5;
      sv = m_valid(); sf = m_fit(); su = m_used();
      drive1();
      @(negedge clk) start1 = 1'b1;
      @(negedge clk) start1 = 1'b0;
      chk("R1 busy", int'(busy1), 1);
      go = 0; ga[0] = N1; drive1();
      start1 = 1'b1;
      @(negedge clk) start1 = 1'b0;
      while (!done1) @(negedge clk);
      chk("R1 ignored valid", int'(val1), sv);
      chk("R1 ignored fitness", int'(fit1), sf);
      chk("R1 ignored used", int'(used1), su);
      @(negedge clk);
      chk("R7 hold fitness", int'(fit1), sf);
      chk("R7 busy low", int'(busy1), 0);

      // R5 random genotypes
      for (int t = 0; t < 40; t++) begin
         for (int j = 0; j < P1; j++) begin
            ga[j] = rnd_src(j);
            gb[j] = rnd_src(j);
            gf[j] = int'($urandom % 2);
         end
         go = ($urandom % 20 == 0) ? int'($urandom % 32) : N1 + P1 - 1 - int'($urandom % 4);
         run1("R5 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule